// File: doc/BRIEF.md
# Framed sample packet assembler

The block collects samples from four ADC channels and turns them into fixed packets for a 32-bit host stream. All four channels deliver one signed 16-bit sample each on a shared strobe. Two strobes, at sample times t and t+1, fill one packet of five 32-bit words. The first word is a wrapping frame number. The next four words each hold the two samples of one channel, in channel order. The host reads the stream with valid/ready handshaking. A gap in the frame numbers tells the host that a packet was lost.

Packets are built only while the acquisition enable is high. System logic raises this enable once the converters have been configured. Lowering the enable does four things:
- it flushes any pending packet;
- it clears the half-collected sample pair;
- it returns the frame number to zero;
- it clears the overflow flag.

The block holds one packet at a time. Suppose a new packet completes while the previous one is still waiting and its last word is not being accepted in that cycle. The new packet is then discarded whole, the sticky overflow flag is set, and the frame number still advances.

Top module: `frame_packer`

## Requirements
- R1: After reset, `out_valid`, `out_last` and `overflow` are low.
- R2: A packet is exactly five words on the stream. Word 0 carries the frame number, zero-extended to 32 bits. `out_last` is high on word 4 only.
- R3: Words 1 to 4 carry channels 0, 1, 2 and 3 in that order. Channel c is taken from `smp_data[16c+15:16c]`.
- R4: In each channel word, the sample from the first strobe of the pair sits in bits 15:0. The sample from the second strobe sits in bits 31:16.
- R5: The frame number starts at zero. It rises by one for every completed sample pair, and it wraps to zero after 2^FRAME_W-1.
- R6: While `acq_en` is low, strobes are ignored, `out_valid` is low one cycle later, and the frame number is held at zero. The first packet after enabling therefore has frame 0 and pairs the first two strobes after enabling.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged on the next cycle.
- R8: A packet that completes while the previous packet is still pending is dropped whole. Dropping sets `overflow`, which stays high until `acq_en` goes low. The frame number still advances past the dropped packet, and the pending packet is delivered intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acq_en | input | 1 | Acquisition enable, raised after converter setup |
| smp_vld | input | 1 | Strobe: one new sample on every channel |
| smp_data | input | NCH*SMP_W | Channel samples, channel 0 in the low bits |
| out_data | output | 32 | Stream word |
| out_valid | output | 1 | Stream word valid |
| out_ready | input | 1 | Host accepts the word |
| out_last | output | 1 | Last word of the packet |
| overflow | output | 1 | Sticky: a packet was dropped |

## Verification
Four behaviours are checked by properties on every cycle:
- stream words stay stable under backpressure;
- `out_last` falls on every fifth accepted word, tracked by a counter that is independent of the design;
- the stream goes quiet one cycle after the enable drops;
- the overflow flag stays sticky and rises only on a sample strobe.

Other behaviours only the bench scenarios can show: the channel order, the placement of the two samples within each word, and the frame numbers. That includes the gap left by a dropped packet, the wrap of a narrow counter, and the restart at zero after re-enabling.

// File: rtl/smp_pkg.sv
// Shared constants for the sample packet assembler.
// Assumes a 32-bit host word that holds two samples of one channel.
package smp_pkg;
    localparam int unsigned WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/smp_pair_capture.sv
// Pairs two consecutive strobes of NCH samples into NCH channel words.
// Assumes all channels strobe together. The first sample of the pair goes
// in the low half, the second in the high half. `done` is combinational
// and marks the strobe that completes a pair.
module smp_pair_capture #(
    parameter int unsigned NCH   = 4,
    parameter int unsigned SMP_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     vld,
    input  logic [NCH*SMP_W-1:0]     data,
    output logic                     done,
    output logic [NCH*2*SMP_W-1:0]   words
);
    logic                 second_q;
    logic [NCH*SMP_W-1:0] early_q;

    // Track which half of the pair is next and keep the earlier samples.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            second_q <= 1'b0;
            early_q  <= '0;
        end else if (vld) begin
            if (!second_q) early_q <= data;
            second_q <= ~second_q;
        end
    end

    // A pair completes on the second strobe.
    always_comb done = en && vld && second_q;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        // Later sample high, earlier sample low.
        always_comb words[c*2*SMP_W +: 2*SMP_W] =
            {data[c*SMP_W +: SMP_W], early_q[c*SMP_W +: SMP_W]};
    end
endmodule

// File: rtl/smp_frame_ctr.sv
// Wrapping frame counter. It is held at zero while disabled and
// advances once per completed sample pair.
module smp_frame_ctr #(
    parameter int unsigned FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               adv,
    output logic [FRAME_W-1:0] cnt
);
    // Count pairs, wrapping naturally at the counter width.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt <= '0;
        else if (adv)      cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/smp_word_serializer.sv
// One-packet buffer that streams NW words with valid/ready.
// The caller loads only when `free` is high. `free` also covers the cycle
// in which the final word is accepted, so back-to-back packets need no bubble.
module smp_word_serializer #(
    parameter int unsigned NW = 5,
    parameter int unsigned WW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             load,
    input  logic [NW*WW-1:0] pkt,
    input  logic             ready,
    output logic             valid,
    output logic [WW-1:0]    data,
    output logic             last,
    output logic             free
);
    localparam int unsigned IDX_W = (NW > 1) ? $clog2(NW) : 1;

    logic             busy_q;
    logic [IDX_W-1:0] idx_q;
    logic [NW*WW-1:0] buf_q;

    // Output view of the buffer.
    always_comb begin
        valid = busy_q;
        last  = busy_q && (idx_q == IDX_W'(NW-1));
        data  = buf_q[idx_q*WW +: WW];
        free  = !busy_q || (ready && last);
    end

    // Load a packet, then step through its words as they are accepted.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            buf_q  <= '0;
        end else if (load) begin
            buf_q  <= pkt;
            busy_q <= 1'b1;
            idx_q  <= '0;
        end else if (busy_q && ready) begin
            if (last) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                idx_q  <= idx_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/frame_packer.sv
// Framed sample packet assembler: a frame word followed by NCH channel words,
// each channel word holding two consecutive samples.
// Assumes 2*SMP_W equals the 32-bit host word and FRAME_W is at most 32.
module frame_packer #(
    parameter int unsigned NCH     = 4,
    parameter int unsigned SMP_W   = 16,
    parameter int unsigned FRAME_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acq_en,
    input  logic                     smp_vld,
    input  logic [NCH*SMP_W-1:0]     smp_data,
    output logic [31:0]              out_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic                     out_last,
    output logic                     overflow
);
    import smp_pkg::*;

    localparam int unsigned NW = NCH + 1;

    logic                      pair_done;
    logic [NCH*2*SMP_W-1:0]    chan_words;
    logic [FRAME_W-1:0]        frame_num;
    logic                      buf_free;
    logic                      do_load;
    logic                      do_drop;
    logic [NW*WORD_W-1:0]      packet;
    logic                      ovf_q;

    smp_pair_capture #(.NCH(NCH), .SMP_W(SMP_W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (acq_en),
        .vld   (smp_vld),
        .data  (smp_data),
        .done  (pair_done),
        .words (chan_words)
    );

    smp_frame_ctr #(.FRAME_W(FRAME_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (acq_en),
        .adv   (pair_done),
        .cnt   (frame_num)
    );

    // Assemble the packet image and decide whether to keep or drop it.
    always_comb begin
        packet  = {chan_words, WORD_W'(frame_num)};
        do_load = pair_done && buf_free;
        do_drop = pair_done && !buf_free;
    end

    smp_word_serializer #(.NW(NW), .WW(WORD_W)) u_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!acq_en),
        .load  (do_load),
        .pkt   (packet),
        .ready (out_ready),
        .valid (out_valid),
        .data  (out_data),
        .last  (out_last),
        .free  (buf_free)
    );

    // Sticky overflow flag, cleared by disabling acquisition.
    always_ff @(posedge clk) begin
        if (!rst_n || !acq_en) ovf_q <= 1'b0;
        else if (do_drop)      ovf_q <= 1'b1;
    end

    always_comb overflow = ovf_q;
endmodule

// File: rtl/frame_packer_chk.sv
// Property checker for frame_packer, attached by bind.
// It keeps its own word counter to locate packet ends.
module frame_packer_chk #(
    parameter int unsigned NCH = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        acq_en,
    input logic        smp_vld,
    input logic [31:0] out_data,
    input logic        out_valid,
    input logic        out_ready,
    input logic        out_last,
    input logic        overflow
);
    localparam int unsigned NW = NCH + 1;

    int unsigned seen_q;

    // Count accepted words within the current packet.
    always_ff @(posedge clk) begin
        if (!rst_n || !acq_en)         seen_q <= 0;
        else if (out_valid && out_ready)
            seen_q <= (seen_q == NW-1) ? 0 : seen_q + 1;
    end

    // R2
    last_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_last == (seen_q == NW-1)));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && acq_en) |=> (out_valid && $stable(out_data)));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acq_en |=> !out_valid);

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && acq_en) |=> overflow);

    // R8
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(smp_vld));
endmodule

bind frame_packer frame_packer_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acq_en    (acq_en),
    .smp_vld   (smp_vld),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_last  (out_last),
    .overflow  (overflow)
);

// File: tb/frame_packer_tb.sv
// Self-checking bench for frame_packer: a vector table walk, then directed cases.
module frame_packer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acq_en = 1'b0;
    logic        smp_vld = 1'b0;
    logic [63:0] smp_data = '0;
    logic        out_ready = 1'b0;
    logic [31:0] od, wod;
    logic        ov, ol, oflow, wov, wol, woflow;

    int nchk = 0;
    int nerr = 0;
    int fr = 0;

    always #5 clk = ~clk;

    frame_packer u_dut (
        .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .smp_vld(smp_vld),
        .smp_data(smp_data), .out_data(od), .out_valid(ov),
        .out_ready(out_ready), .out_last(ol), .overflow(oflow)
    );

    // Narrow frame counter to reach the wrap quickly (R5).
    frame_packer #(.FRAME_W(3)) u_wrap (
        .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .smp_vld(smp_vld),
        .smp_data(smp_data), .out_data(wod), .out_valid(wov),
        .out_ready(out_ready), .out_last(wol), .overflow(woflow)
    );

    // Stimulus table: {second strobe, first strobe}. Expected words follow R3/R4.
    localparam logic [127:0] TBL [4] = '{
        {64'h4444_3333_2222_1111, 64'hDDDD_CCCC_BBBB_AAAA},
        {64'h7FFF_8000_0001_FFFF, 64'h8000_7FFF_FFFF_0001},
        {64'h0000_0000_0000_0000, 64'h1234_5678_9ABC_DEF0},
        {64'hFEDC_BA98_7654_3210, 64'h0F0F_F0F0_00FF_FF00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Two strobes; returns at the negedge after the second.
    task automatic send_pair(input logic [63:0] a, input logic [63:0] b);
        @(negedge clk); smp_vld = 1'b1; smp_data = a;
        @(negedge clk); smp_data = b;
        @(negedge clk); smp_vld = 1'b0;
    endtask

    // Drain one packet with ready high, checking every word.
    task automatic collect(input logic [63:0] a, input logic [63:0] b, input int f);
        out_ready = 1'b1;
        for (int i = 0; i < 5; i++) begin
            chk("R2 valid", {31'd0, ov}, 32'd1);
            chk("R2 last", {31'd0, ol}, {31'd0, i == 4});
            if (i == 0) begin
                chk("R5 frame", od, f);
                chk("R5 wrap frame", wod, f & 7);
            end else begin
                chk("R3 R4 channel word", od, {b[16*(i-1) +: 16], a[16*(i-1) +: 16]});
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk("R2 end of packet", {31'd0, ov}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : main
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 valid", {31'd0, ov}, 32'd0);
        chk("R1 last", {31'd0, ol}, 32'd0);
        chk("R1 overflow", {31'd0, oflow}, 32'd0);
        rst_n = 1'b1;

        // R6 disabled: strobes ignored, including an odd single strobe
        send_pair(64'h1, 64'h2);
        @(negedge clk); smp_vld = 1'b1; smp_data = 64'h9;
        @(negedge clk); smp_vld = 1'b0;
        chk("R6 no output while disabled", {31'd0, ov}, 32'd0);
        acq_en = 1'b1;
        send_pair(64'h0002_0004_0006_0008, 64'h0001_0003_0005_0007);
        collect(64'h0002_0004_0006_0008, 64'h0001_0003_0005_0007, 0);
        fr = 1;

        // Table walk (R3 R4 R5)
        for (int e = 0; e < 4; e++) begin
            send_pair(TBL[e][63:0], TBL[e][127:64]);
            collect(TBL[e][63:0], TBL[e][127:64], fr);
            fr++;
        end

        // R5 wrap of the narrow counter: frames 5..13 cross 8
        for (int k = 0; k < 9; k++) begin
            logic [63:0] a, b;
            a = {4{16'(k * 3 + 1)}};
            b = {4{16'(16'hF000 + k)}};
            send_pair(a, b);
            collect(a, b, fr);
            fr++;
        end

        // R7 backpressure and R8 overflow
        send_pair(TBL[0][63:0], TBL[0][127:64]);
        repeat (3) @(negedge clk);
        chk("R7 held valid", {31'd0, ov}, 32'd1);
        chk("R7 held word", od, fr);
        send_pair(TBL[1][63:0], TBL[1][127:64]);
        chk("R8 overflow set", {31'd0, oflow}, 32'd1);
        chk("R8 pending kept", od, fr);
        collect(TBL[0][63:0], TBL[0][127:64], fr);
        fr += 2;
        send_pair(TBL[2][63:0], TBL[2][127:64]);
        collect(TBL[2][63:0], TBL[2][127:64], fr);
        chk("R8 overflow sticky", {31'd0, oflow}, 32'd1);

        // R6 disable flushes a pending packet, clears overflow, restarts frames
        send_pair(TBL[3][63:0], TBL[3][127:64]);
        acq_en = 1'b0;
        @(negedge clk);
        chk("R6 flushed", {31'd0, ov}, 32'd0);
        chk("R8 overflow cleared", {31'd0, oflow}, 32'd0);
        acq_en = 1'b1;
        send_pair(TBL[1][63:0], TBL[1][127:64]);
        collect(TBL[1][63:0], TBL[1][127:64], 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule